// File: doc/BRIEF.md
# LIN Sync Byte Bit-Period Meter

This block measures the bit time of an incoming LIN frame from the 0x55 synchronization byte that follows the break. An external break detector pulses a strobe once the break has been seen. The meter then watches a resynchronized copy of the serial line and counts falling edges. On the first falling edge it latches the value of a free-running timer. On the fifth falling edge it latches the timer again. Each capture raises its own sticky interrupt status bit.

The 0x55 byte framed by its start bit has falling edges at bit positions 0, 2, 4, 6 and 8. The first and fifth edges are therefore exactly eight bit times apart. The block subtracts the two timestamps modulo the timer width and shifts the difference right by three. The result is a bit period in timer ticks, which software or a baud generator uses to retune the local rate. A done flag marks the period as valid. After the fifth edge the meter goes idle, and it ignores the line until the next break strobe.

Top module: `lin_baud_meter`

## Requirements
- R1: Falling edges on `rx_i` that arrive while the meter is not armed (after reset, or after a measurement has finished) change neither the captures nor the status bits nor `done_o`. Only a one-cycle high on `brk_det_i` arms the meter.
- R2: When the meter is armed and `rx_i` is first sampled low by a clock edge n after being high, `t1_o` takes the `tmr_i` value sampled at edge n+2. This latency comes from two synchronizer stages plus one edge-compare register.
- R3: The first-edge capture sets `irq_first_o` to 1.
- R4: The fifth falling edge after arming is captured into `t2_o` with the same latency as in R2, and it sets `irq_fifth_o` to 1.
- R5: `bit_period_o` equals ((`t2_o` − `t1_o`) mod 2^TMR_W) shifted right by 3, rounded down. This stays correct when the timer wraps between the two edges.
- R6: `done_o` rises one clock edge after the fifth-edge capture. It holds until a break strobe clears it.
- R7: Each status bit stays set until a clear pulse on its own bit of `sts_clr_i`: bit 0 clears `irq_first_o` and bit 1 clears `irq_fifth_o`. A clear pulse leaves the other bit unchanged.
- R8: After the fifth edge, any further falling edges before the next break strobe leave `t1_o`, `t2_o`, both status bits and `done_o` unchanged.
- R9: A break strobe that arrives while a measurement is in progress restarts the edge count from zero. The next falling edge becomes the new first edge.
- R10: After reset, `t1_o`, `t2_o`, `bit_period_o`, both status bits and `done_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| tmr_i | input | TMR_W | Free-running timer value |
| brk_det_i | input | 1 | One-cycle strobe from the break detector; arms the meter |
| sts_clr_i | input | 2 | Write-one-to-clear pulses: bit 0 first-edge status, bit 1 fifth-edge status |
| t1_o | output | TMR_W | Timer captured at the first falling edge |
| t2_o | output | TMR_W | Timer captured at the fifth falling edge |
| irq_first_o | output | 1 | Sticky first-edge status |
| irq_fifth_o | output | 1 | Sticky fifth-edge status |
| bit_period_o | output | TMR_W | Measured bit period in timer ticks |
| done_o | output | 1 | Bit period valid |

## Verification
The meter is driven with uniform sync bytes whose bit length sweeps from 2 to 33 clocks. Some of these frames start the timer just below its wrap point, so that the modulo subtraction is separated from a plain one. Frames with uneven bit lengths give edge gaps that are not multiples of eight, which checks that the division truncates.

Other cases test the gating of the edge counter. Frames are sent with no preceding break and after a finished measurement, to check that unarmed edges are ignored. A break that lands in the middle of a measurement checks that the count restarts. Per-bit clear pulses check that each status bit is cleared on its own.

// File: rtl/lin_meter_pkg.sv
package lin_meter_pkg;
   typedef enum logic {
      MTR_IDLE  = 1'b0,
      MTR_ARMED = 1'b1
   } mtr_state_t;

   typedef struct packed {
      logic first;
      logic last;
   } edge_stb_t;
endpackage

// File: rtl/rx_fall_detect.sv
module rx_fall_detect #(
   parameter int   STAGES   = 2,
   parameter logic IDLE_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_i,
   output logic fall_o
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= IDLE_LVL;
               else        chain_q[0] <= rx_i;
            end
         end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= IDLE_LVL;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= IDLE_LVL;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign fall_o = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/edge_sequencer.sv
module edge_sequencer
   import lin_meter_pkg::*;
#(
   parameter int EDGE_LAST = 5,
   localparam int CNT_W    = $clog2(EDGE_LAST)
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      arm_i,
   input  logic      fall_i,
   output edge_stb_t stb_o
);
   mtr_state_t       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             take;

   assign take        = (state_q == MTR_ARMED) && fall_i && !arm_i;
   assign stb_o.first = take && (cnt_q == '0);
   assign stb_o.last  = take && (cnt_q == CNT_W'(EDGE_LAST - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= MTR_IDLE;
         cnt_q   <= '0;
      end else if (arm_i) begin
         state_q <= MTR_ARMED;
         cnt_q   <= '0;
      end else if (take) begin
         if (stb_o.last) begin
            state_q <= MTR_IDLE;
            cnt_q   <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/period_calc.sv
module period_calc #(
   parameter int TMR_W      = 16,
   parameter int SHIFT      = 3,
   parameter bit PERIOD_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TMR_W-1:0] t1_i,
   input  logic [TMR_W-1:0] t2_i,
   input  logic             start_i,
   input  logic             clr_i,
   output logic [TMR_W-1:0] period_o,
   output logic             valid_o
);
   logic [TMR_W-1:0] span;

   assign span = t2_i - t1_i;

   generate
      if (PERIOD_REG) begin : g_reg
         logic             go_q;
         logic             valid_q;
         logic [TMR_W-1:0] period_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               go_q     <= 1'b0;
               valid_q  <= 1'b0;
               period_q <= '0;
            end else if (clr_i) begin
               go_q    <= 1'b0;
               valid_q <= 1'b0;
            end else begin
               go_q <= start_i;
               if (go_q) begin
                  period_q <= span >> SHIFT;
                  valid_q  <= 1'b1;
               end
            end
         end
         assign period_o = period_q;
         assign valid_o  = valid_q;
      end else begin : g_comb
         logic valid_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       valid_q <= 1'b0;
            else if (clr_i)   valid_q <= 1'b0;
            else if (start_i) valid_q <= 1'b1;
         end
         assign period_o = span >> SHIFT;
         assign valid_o  = valid_q;
      end
   endgenerate
endmodule

// File: rtl/lin_baud_meter.sv
module lin_baud_meter
   import lin_meter_pkg::*;
#(
   parameter int TMR_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int EDGE_LAST   = 5,
   parameter bit PERIOD_REG  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_i,
   input  logic [TMR_W-1:0] tmr_i,
   input  logic             brk_det_i,
   input  logic [1:0]       sts_clr_i,
   output logic [TMR_W-1:0] t1_o,
   output logic [TMR_W-1:0] t2_o,
   output logic             irq_first_o,
   output logic             irq_fifth_o,
   output logic [TMR_W-1:0] bit_period_o,
   output logic             done_o
);
   localparam int SPAN_BITS = 2 * (EDGE_LAST - 1);
   localparam int SHIFT     = $clog2(SPAN_BITS);

   generate
      if (TMR_W < 4) begin : g_bad_width
         $error("lin_baud_meter: TMR_W must be at least 4");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("lin_baud_meter: SYNC_STAGES must be at least 2");
      end
      if (EDGE_LAST < 2) begin : g_bad_edges
         $error("lin_baud_meter: EDGE_LAST must be at least 2");
      end
      if ((1 << SHIFT) != SPAN_BITS) begin : g_bad_span
         $error("lin_baud_meter: edge span must be a power of two bit times");
      end
   endgenerate

   logic             fall;
   edge_stb_t        stb;
   logic             first_stb;
   logic             last_stb;
   logic [TMR_W-1:0] t1_q;
   logic [TMR_W-1:0] t2_q;
   logic             sts_first_q;
   logic             sts_fifth_q;

   rx_fall_detect #(
      .STAGES   (SYNC_STAGES),
      .IDLE_LVL (1'b1)
   ) u_fall (
      .clk    (clk),
      .rst_n  (rst_n),
      .rx_i   (rx_i),
      .fall_o (fall)
   );

   edge_sequencer #(
      .EDGE_LAST (EDGE_LAST)
   ) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm_i  (brk_det_i),
      .fall_i (fall),
      .stb_o  (stb)
   );

   assign first_stb = stb.first;
   assign last_stb  = stb.last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t1_q <= '0;
         t2_q <= '0;
      end else begin
         if (first_stb) t1_q <= tmr_i;
         if (last_stb)  t2_q <= tmr_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_first_q <= 1'b0;
         sts_fifth_q <= 1'b0;
      end else begin
         if (first_stb)         sts_first_q <= 1'b1;
         else if (sts_clr_i[0]) sts_first_q <= 1'b0;
         if (last_stb)          sts_fifth_q <= 1'b1;
         else if (sts_clr_i[1]) sts_fifth_q <= 1'b0;
      end
   end

   period_calc #(
      .TMR_W      (TMR_W),
      .SHIFT      (SHIFT),
      .PERIOD_REG (PERIOD_REG)
   ) u_calc (
      .clk      (clk),
      .rst_n    (rst_n),
      .t1_i     (t1_q),
      .t2_i     (t2_q),
      .start_i  (last_stb),
      .clr_i    (brk_det_i),
      .period_o (bit_period_o),
      .valid_o  (done_o)
   );

   assign t1_o        = t1_q;
   assign t2_o        = t2_q;
   assign irq_first_o = sts_first_q;
   assign irq_fifth_o = sts_fifth_q;
endmodule

// File: rtl/lin_baud_meter_chk.sv
module lin_baud_meter_chk #(
   parameter int TMR_W = 16,
   parameter int SHIFT = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             brk_det_i,
   input logic [1:0]       sts_clr_i,
   input logic [TMR_W-1:0] t1_o,
   input logic [TMR_W-1:0] t2_o,
   input logic             irq_first_o,
   input logic             irq_fifth_o,
   input logic [TMR_W-1:0] bit_period_o,
   input logic             done_o,
   input logic             first_stb,
   input logic             last_stb
);
   logic seen_brk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         seen_brk_q <= 1'b0;
      else if (brk_det_i) seen_brk_q <= 1'b1;
      else if (last_stb)  seen_brk_q <= 1'b0;
   end

   assert_capture_armed_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (first_stb || last_stb) |-> seen_brk_q);

   assert_t1_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !first_stb |=> $stable(t1_o));

   assert_t2_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !last_stb |=> $stable(t2_o));

   assert_first_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      first_stb |=> irq_first_o);

   assert_period_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (bit_period_o == TMR_W'(TMR_W'(t2_o - t1_o) >> SHIFT)));

   assert_done_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done_o) |-> $past(brk_det_i));

   assert_first_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_first_o && !sts_clr_i[0]) |=> irq_first_o);

   assert_fifth_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_fifth_o && !sts_clr_i[1]) |=> irq_fifth_o);
endmodule

bind lin_baud_meter lin_baud_meter_chk #(
   .TMR_W (TMR_W),
   .SHIFT (SHIFT)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .brk_det_i    (brk_det_i),
   .sts_clr_i    (sts_clr_i),
   .t1_o         (t1_o),
   .t2_o         (t2_o),
   .irq_first_o  (irq_first_o),
   .irq_fifth_o  (irq_fifth_o),
   .bit_period_o (bit_period_o),
   .done_o       (done_o),
   .first_stb    (first_stb),
   .last_stb     (last_stb)
);

// File: tb/test_lin_baud_meter.sv
module test_lin_baud_meter;
   localparam int CLK_PERIOD = 10;
   localparam int TW         = 16;
   localparam int SYNC       = 2;
   localparam int WDOG       = 150000;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          rx;
   logic [TW-1:0] tmr;
   logic          brk;
   logic [1:0]    clr;
   logic [TW-1:0] t1, t2, period;
   logic          irq1, irq5, done;

   int            n_chk  = 0;
   int            n_fail = 0;
   bit            ended  = 1'b0;

   logic          load_pend = 1'b0;
   logic [TW-1:0] load_val  = '0;
   logic          prev_rx   = 1'b1;
   int            nfall     = 0;
   logic [TW-1:0] stamp [1:10];

   always #(CLK_PERIOD/2) clk = ~clk;

   lin_baud_meter #(.TMR_W(TW), .SYNC_STAGES(SYNC)) i_lin_baud_meter (
      .clk          (clk),
      .rst_n        (rst_n),
      .rx_i         (rx),
      .tmr_i        (tmr),
      .brk_det_i    (brk),
      .sts_clr_i    (clr),
      .t1_o         (t1),
      .t2_o         (t2),
      .irq_first_o  (irq1),
      .irq_fifth_o  (irq5),
      .bit_period_o (period),
      .done_o       (done)
   );

   initial begin
      tmr = '0;
      forever begin
         @(negedge clk);
         if (load_pend) begin
            tmr = load_val;
            load_pend = 1'b0;
         end else begin
            tmr = tmr + 1'b1;
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary;
      if (!ended) begin
         ended = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic drive(input logic b, input int n);
      @(negedge clk);
      rx = b;
      #1;
      if (prev_rx && !b) begin
         nfall++;
         if (nfall <= 10) stamp[nfall] = tmr;
      end
      prev_rx = b;
      repeat (n - 1) @(negedge clk);
   endtask

   task automatic brk_pulse;
      @(negedge clk);
      brk = 1'b1;
      @(negedge clk);
      brk = 1'b0;
      nfall = 0;
   endtask

   task automatic load_timer(input logic [TW-1:0] v);
      @(negedge clk);
      load_val  = v;
      load_pend = 1'b1;
      @(negedge clk);
   endtask

   task automatic send_frame(input int d [10]);
      for (int i = 0; i < 10; i++) begin
         logic b;
         b = (i == 0) ? 1'b0 : (i == 9) ? 1'b1 : ((i % 2) == 1);
         drive(b, d[i]);
      end
      drive(1'b1, 8);
   endtask

   task automatic clear_sts(input logic [1:0] m);
      @(negedge clk);
      clr = m;
      @(negedge clk);
      clr = 2'b00;
      #1;
   endtask

   task automatic check_result;
      logic [TW-1:0] e1, e2, ep;
      e1 = stamp[1] + TW'(SYNC);
      e2 = stamp[5] + TW'(SYNC);
      ep = TW'(stamp[5] - stamp[1]) >> 3;
      chk("R2 t1", t1, e1);
      chk("R3 irq_first", irq1, 1'b1);
      chk("R4 t2", t2, e2);
      chk("R4 irq_fifth", irq5, 1'b1);
      chk("R5 period", period, ep);
      chk("R6 done", done, 1'b1);
   endtask

   initial begin
      repeat (WDOG) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      int d [10];
      logic [TW-1:0] s1, s2;
      rst_n = 1'b0;
      rx    = 1'b1;
      brk   = 1'b0;
      clr   = 2'b00;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R10: reset values
      chk("R10 t1", t1, 0);
      chk("R10 t2", t2, 0);
      chk("R10 period", period, 0);
      chk("R10 irq_first", irq1, 0);
      chk("R10 irq_fifth", irq5, 0);
      chk("R10 done", done, 0);

      // R1: frame with no break strobe is ignored
      for (int i = 0; i < 10; i++) d[i] = 4;
      send_frame(d);
      chk("R1 t1", t1, 0);
      chk("R1 irq_first", irq1, 0);
      chk("R1 done", done, 0);

      // uniform sweep over bit lengths, some across timer wrap
      for (int b = 2; b <= 33; b++) begin
         if ((b % 5) == 0) load_timer(TW'(17'h10000 - 3 * b));
         brk_pulse();
         chk("R6 done cleared by break", done, 0);
         drive(1'b1, 3);
         for (int i = 0; i < 10; i++) d[i] = b;
         send_frame(d);
         check_result();
         clear_sts(2'b01);
         chk("R7 first cleared", irq1, 0);
         chk("R7 fifth kept", irq5, 1);
         clear_sts(2'b10);
         chk("R7 fifth cleared", irq5, 0);
      end

      // uneven bit lengths: gaps not a multiple of eight
      for (int k = 0; k < 10; k++) begin
         if (k == 4) load_timer(16'hFFC0);
         brk_pulse();
         drive(1'b1, 2);
         for (int i = 0; i < 10; i++) d[i] = 12 + ((i * 3 + k) % 5) - 2;
         send_frame(d);
         check_result();
         clear_sts(2'b11);
      end

      // R8: edges after completion are ignored
      s1 = t1;
      s2 = t2;
      for (int i = 0; i < 10; i++) d[i] = 7;
      send_frame(d);
      chk("R8 t1 held", t1, s1);
      chk("R8 t2 held", t2, s2);
      chk("R8 irq_first", irq1, 0);
      chk("R8 irq_fifth", irq5, 0);
      chk("R8 done held", done, 1);

      // R9: break during measurement restarts counting
      brk_pulse();
      drive(1'b1, 3);
      drive(1'b0, 4);
      drive(1'b1, 4);
      drive(1'b0, 4);
      drive(1'b1, 4);
      brk_pulse();
      drive(1'b1, 3);
      for (int i = 0; i < 10; i++) d[i] = 9;
      send_frame(d);
      chk("R9 restart t1", t1, stamp[1] + TW'(SYNC));
      chk("R9 restart period", period, 9);
      check_result();

      summary();
   end
endmodule